// File: doc/BRIEF.md
# Zero-Crossing Synchronized Nibble Receiver

This block rebuilds bytes from a mains-line link that sends half a byte in each half-cycle of the AC supply. A one-cycle pulse marks each zero crossing of the line. A demodulated serial bit stream comes in beside it. After every crossing the receiver waits a fixed offset, which puts the frame window past the noisy region around the peak. It then takes seven bits, one at the middle of each bit period. Everything after the seventh bit, up to the next crossing, is dead time and the receiver does not look at it.

Each half-cycle frame carries these bits in this order: a frame/data marker, a cycle bit, four payload bits with the lowest index first, and a parity bit. The cycle bit tells which half of the byte the payload holds. The receiver checks parity and joins a low half and the high half that follows it into one byte. It reports whether that byte starts a message or is a data/checksum byte. It raises single-cycle error pulses for corrupted frames and for halves that do not pair up legally. Demodulation, message checksums and the higher protocol layers are done elsewhere.

Top module: `zc_nibble_rx`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `byte_valid`, `parity_err` and `seq_err` are 0 and `byte_data` is 0x00.
- R2: After a `zc_pulse`, bit k (k = 0..6) of the frame is sampled `OFFSET_CYC + k*BIT_CYC + BIT_CYC/2` cycles after the pulse edge. The `rx_data` value is ignored in the offset, at the other cycles of each bit period, and in the dead time. At most one result event appears per zero crossing.
- R3: Frame bit order is: bit 0 marker, bit 1 cycle, bits 2..5 payload (bit 2 is the lowest payload bit), bit 6 parity. A cycle bit of 0 carries byte bits 3:0 and a cycle bit of 1 carries byte bits 7:4. A valid low half followed by a valid high half produces `byte_data = {high, low}`. `byte_data` changes only in a cycle where `byte_valid` is 1.
- R4: Parity is even and covers the marker bit and the four payload bits. The cycle bit is not included. A frame that fails parity raises `parity_err` for one cycle and discards any stored low half.
- R5: A byte whose two halves both have marker 0 is output with `byte_valid` = 1 for one cycle and `byte_is_frame` = 1.
- R6: A byte with marker 1 that completes before any marker-0 byte has been accepted since reset is discarded, and `seq_err` pulses for one cycle.
- R7: A high-half frame whose immediately preceding frame was not a valid low half raises `seq_err` and produces no byte.
- R8: If the marker bits of the low half and the high half differ, the byte is discarded and `seq_err` pulses.
- R9: After a marker-0 byte has been accepted, a byte with marker 1 on both halves is output with `byte_valid` = 1 and `byte_is_frame` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_pulse | input | 1 | One-cycle pulse at each mains zero crossing |
| rx_data | input | 1 | Demodulated serial line data, already synchronized to `clk` |
| byte_valid | output | 1 | One-cycle strobe: a byte has been assembled |
| byte_data | output | 8 | Last assembled byte; holds its value between strobes |
| byte_is_frame | output | 1 | 1 when the assembled byte is a message-start byte |
| parity_err | output | 1 | One-cycle pulse: a frame failed even parity |
| seq_err | output | 1 | One-cycle pulse: the halves paired illegally or data came before a frame byte |

## Verification
The hardest conditions to reach are the ones where a half-cycle goes missing or does not fit with its neighbour. Examples are a high half with no low half before it, a high half that follows a low half dropped for bad parity, and two halves whose markers differ. The driver builds each half-cycle frame on its own, with any marker, cycle bit and parity it is given. The stimulus can therefore send lone high halves, corrupt one half of a pair, or mix markers, and push only the error event that the requirements predict. To show that samples are taken only at the midpoints, the driver puts inverted or toggling data in the offset, in the first cycle of every bit period and in the dead time.

// File: rtl/zcnr_pkg.sv
package zcnr_pkg;

    localparam int FRAME_BITS = 7;
    localparam int IDX_W      = 3;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_OFFSET = 2'd1,
        PH_BITS   = 2'd2
    } phase_e;

    typedef struct packed {
        logic       marker;
        logic       cycle;
        logic [3:0] nibble;
        logic       parity;
    } frame_t;

    typedef struct packed {
        logic       valid;
        logic       is_frame;
        logic [7:0] data;
        logic       par_err;
        logic       seq_err;
    } result_t;

    function automatic logic parity_ok(frame_t f);
        return ~(^{f.marker, f.nibble, f.parity});
    endfunction

endpackage

// File: rtl/zcnr_timer.sv
module zcnr_timer
    import zcnr_pkg::*;
#(
    parameter int OFFSET_CYC = 12,
    parameter int BIT_CYC    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zc_pulse,
    output logic             sample_stb,
    output logic [IDX_W-1:0] bit_idx
);
    localparam int MAXC = (OFFSET_CYC > BIT_CYC) ? OFFSET_CYC : BIT_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int HALF = BIT_CYC / 2;

    phase_e        phase;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
        end else if (zc_pulse) begin
            phase   <= PH_OFFSET;
            cnt     <= '0;
            bit_idx <= '0;
        end else begin
            unique case (phase)
                PH_OFFSET: begin
                    if (cnt == CW'(OFFSET_CYC - 1)) begin
                        phase <= PH_BITS;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_BITS: begin
                    if (cnt == CW'(BIT_CYC - 1)) begin
                        cnt <= '0;
                        if (bit_idx == IDX_W'(FRAME_BITS - 1)) begin
                            phase   <= PH_IDLE;
                            bit_idx <= '0;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    assign sample_stb = (phase == PH_BITS) && (cnt == CW'(HALF)) && !zc_pulse;

endmodule

// File: rtl/zcnr_capture.sv
module zcnr_capture
    import zcnr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_stb,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             rx_data,
    output logic             frame_vld,
    output frame_t           frame
);
    logic [FRAME_BITS-2:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            frame_vld <= 1'b0;
            if (sample_stb) begin
                for (int i = 0; i < FRAME_BITS - 1; i++) begin
                    if (bit_idx == IDX_W'(i)) shreg[i] <= rx_data;
                end
                if (bit_idx == IDX_W'(FRAME_BITS - 1)) begin
                    frame_vld     <= 1'b1;
                    frame.marker  <= shreg[0];
                    frame.cycle   <= shreg[1];
                    frame.nibble  <= shreg[5:2];
                    frame.parity  <= rx_data;
                end
            end
        end
    end

endmodule

// File: rtl/zcnr_assembler.sv
module zcnr_assembler
    import zcnr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    frame_vld,
    input  frame_t  frame,
    output result_t res
);
    logic       have_low;
    logic [3:0] low_nib;
    logic       low_marker;
    logic       seen_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_low   <= 1'b0;
            low_nib    <= '0;
            low_marker <= 1'b0;
            seen_frame <= 1'b0;
            res        <= '0;
        end else begin
            res.valid   <= 1'b0;
            res.par_err <= 1'b0;
            res.seq_err <= 1'b0;
            if (frame_vld) begin
                if (!parity_ok(frame)) begin
                    res.par_err <= 1'b1;
                    have_low    <= 1'b0;
                end else if (!frame.cycle) begin
                    have_low   <= 1'b1;
                    low_nib    <= frame.nibble;
                    low_marker <= frame.marker;
                end else begin
                    have_low <= 1'b0;
                    if (!have_low || (frame.marker != low_marker)) begin
                        res.seq_err <= 1'b1;
                    end else if (frame.marker && !seen_frame) begin
                        res.seq_err <= 1'b1;
                    end else begin
                        res.valid    <= 1'b1;
                        res.is_frame <= ~frame.marker;
                        res.data     <= {frame.nibble, low_nib};
                        if (!frame.marker) seen_frame <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/zc_nibble_rx.sv
module zc_nibble_rx
    import zcnr_pkg::*;
#(
    parameter int OFFSET_CYC = 12,
    parameter int BIT_CYC    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       zc_pulse,
    input  logic       rx_data,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       byte_is_frame,
    output logic       parity_err,
    output logic       seq_err
);
    logic             sample_stb;
    logic [IDX_W-1:0] bit_idx;
    logic             frame_vld;
    frame_t           frame;
    result_t          res;

    zcnr_timer #(.OFFSET_CYC(OFFSET_CYC), .BIT_CYC(BIT_CYC)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .zc_pulse   (zc_pulse),
        .sample_stb (sample_stb),
        .bit_idx    (bit_idx)
    );

    zcnr_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .sample_stb (sample_stb),
        .bit_idx    (bit_idx),
        .rx_data    (rx_data),
        .frame_vld  (frame_vld),
        .frame      (frame)
    );

    zcnr_assembler u_asm (
        .clk       (clk),
        .rst       (rst),
        .frame_vld (frame_vld),
        .frame     (frame),
        .res       (res)
    );

    assign byte_valid    = res.valid;
    assign byte_data     = res.data;
    assign byte_is_frame = res.is_frame;
    assign parity_err    = res.par_err;
    assign seq_err       = res.seq_err;

endmodule

// File: rtl/zcnr_checker.sv
module zcnr_checker (
    input logic       clk,
    input logic       rst,
    input logic       zc_pulse,
    input logic       sample_stb,
    input logic       frame_vld,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       byte_is_frame,
    input logic       parity_err,
    input logic       seq_err
);
    logic [3:0] stb_since_zc;
    logic       frame_seen;

    always_ff @(posedge clk) begin
        if (rst || zc_pulse) stb_since_zc <= '0;
        else if (sample_stb)  stb_since_zc <= stb_since_zc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) frame_seen <= 1'b0;
        else if (byte_valid && byte_is_frame) frame_seen <= 1'b1;
    end

    AST_SEVEN_SAMPLES: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (stb_since_zc < 4'd7));  // R2

    AST_EVENT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (byte_valid || parity_err || seq_err) |-> $past(frame_vld));  // R2

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({byte_valid, parity_err, seq_err}));  // R4

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !$stable(byte_data) |-> byte_valid);  // R3

    AST_FRAME_FIRST: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_is_frame) |-> frame_seen);  // R6

endmodule

bind zc_nibble_rx zcnr_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .zc_pulse      (zc_pulse),
    .sample_stb    (sample_stb),
    .frame_vld     (frame_vld),
    .byte_valid    (byte_valid),
    .byte_data     (byte_data),
    .byte_is_frame (byte_is_frame),
    .parity_err    (parity_err),
    .seq_err       (seq_err)
);

// File: tb/tb_zc_nibble_rx.sv
module tb_zc_nibble_rx;
    localparam int OFFSET_CYC = 12;
    localparam int BIT_CYC    = 8;
    localparam int DEAD_CYC   = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zc_pulse = 1'b0;
    logic       rx_data = 1'b0;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       byte_is_frame;
    logic       parity_err;
    logic       seq_err;

    int tests  = 0;
    int failed = 0;

    typedef struct {
        int         kind;   // 0 byte, 1 parity error, 2 sequence error
        logic [7:0] data;
        logic       is_frame;
        string      req;
    } ev_t;
    ev_t exp_q[$];

    always #2 clk = ~clk;

    zc_nibble_rx #(.OFFSET_CYC(OFFSET_CYC), .BIT_CYC(BIT_CYC)) dut (
        .clk           (clk),
        .rst           (rst),
        .zc_pulse      (zc_pulse),
        .rx_data       (rx_data),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .byte_is_frame (byte_is_frame),
        .parity_err    (parity_err),
        .seq_err       (seq_err)
    );

    task automatic check(bit ok, string req, string what, int act, int expv);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic expect_ev(int kind, logic [7:0] d, logic f, string req);
        ev_t e;
        e.kind = kind; e.data = d; e.is_frame = f; e.req = req;
        exp_q.push_back(e);
    endtask

    // One half-cycle: zero crossing, offset, 7 bits, dead time.
    task automatic send_half(logic marker, logic cyc, logic [3:0] nib, bit corrupt);
        logic [6:0] bits;
        logic par;
        par  = marker ^ (^nib) ^ corrupt;
        bits = {par, nib, cyc, marker};
        @(negedge clk); zc_pulse = 1'b1; rx_data = ~rx_data;
        @(negedge clk); zc_pulse = 1'b0;
        for (int i = 0; i < OFFSET_CYC - 1; i++) begin
            rx_data = ~rx_data;
            @(negedge clk);
        end
        for (int k = 0; k < 7; k++) begin
            rx_data = ~bits[k];
            @(negedge clk);
            rx_data = bits[k];
            repeat (BIT_CYC - 1) @(negedge clk);
        end
        for (int i = 0; i < DEAD_CYC; i++) begin
            rx_data = ~rx_data;
            @(negedge clk);
        end
    endtask

    // Monitor: compares every result event against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (byte_valid || parity_err || seq_err)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected event",
                          {byte_valid, parity_err, seq_err}, 0);
                end else begin
                    ev_t e;
                    int act_kind;
                    e = exp_q.pop_front();
                    act_kind = byte_valid ? 0 : (parity_err ? 1 : 2);
                    check(act_kind == e.kind, e.req, "event kind", act_kind, e.kind);
                    if (e.kind == 0) begin
                        check(byte_data == e.data, e.req, "byte_data", byte_data, e.data);
                        check(byte_is_frame == e.is_frame, e.req, "byte_is_frame",
                              byte_is_frame, e.is_frame);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failed++;
        tests++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(byte_valid == 1'b0, "R1", "byte_valid in reset", byte_valid, 0);
        check(parity_err == 1'b0, "R1", "parity_err in reset", parity_err, 0);
        check(seq_err == 1'b0, "R1", "seq_err in reset", seq_err, 0);
        rst = 1'b0;
        @(negedge clk);
        check(byte_data == 8'h00, "R1", "byte_data after reset", byte_data, 0);
        check(byte_valid == 1'b0, "R1", "byte_valid after reset", byte_valid, 0);

        // R6: data byte before any frame byte
        expect_ev(2, 8'h00, 1'b0, "R6");
        send_half(1'b1, 1'b0, 4'h5, 1'b0);
        send_half(1'b1, 1'b1, 4'hA, 1'b0);
        check(byte_data == 8'h00, "R6", "byte_data after discard", byte_data, 0);

        // R5, R3: frame byte 0xC3
        expect_ev(0, 8'hC3, 1'b1, "R5");
        send_half(1'b0, 1'b0, 4'h3, 1'b0);
        send_half(1'b0, 1'b1, 4'hC, 1'b0);

        // R9: data byte 0x0F
        expect_ev(0, 8'h0F, 1'b0, "R9");
        send_half(1'b1, 1'b0, 4'hF, 1'b0);
        send_half(1'b1, 1'b1, 4'h0, 1'b0);

        // R4 then R7: bad low half drops, the high half then has no partner
        expect_ev(1, 8'h00, 1'b0, "R4");
        expect_ev(2, 8'h00, 1'b0, "R7");
        send_half(1'b1, 1'b0, 4'h1, 1'b1);
        send_half(1'b1, 1'b1, 4'h2, 1'b0);
        check(byte_data == 8'h0F, "R4", "byte_data held after drop", byte_data, 8'h0F);

        // R7: lone high half after a completed byte
        expect_ev(2, 8'h00, 1'b0, "R7");
        send_half(1'b1, 1'b1, 4'h7, 1'b0);

        // R8: mismatched markers
        expect_ev(2, 8'h00, 1'b0, "R8");
        send_half(1'b0, 1'b0, 4'h4, 1'b0);
        send_half(1'b1, 1'b1, 4'h5, 1'b0);

        // R4: bad parity on the high half
        expect_ev(1, 8'h00, 1'b0, "R4");
        send_half(1'b1, 1'b0, 4'h6, 1'b0);
        send_half(1'b1, 1'b1, 4'h9, 1'b1);

        // R3, R9: byte 0xA5; the cycle bit stays out of parity
        expect_ev(0, 8'hA5, 1'b0, "R3");
        send_half(1'b1, 1'b0, 4'h5, 1'b0);
        send_half(1'b1, 1'b1, 4'hA, 1'b0);

        // R5: second frame byte 0x7E
        expect_ev(0, 8'h7E, 1'b1, "R5");
        send_half(1'b0, 1'b0, 4'hE, 1'b0);
        send_half(1'b0, 1'b1, 4'h7, 1'b0);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R2", "events missing", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule